// File: doc/BRIEF.md
# Prescaled PWM Timer

A single-channel pulse-width generator set up through a byte-wide register port. The system clock is divided down to a fixed 32 kHz base tick. A period counter advances once per tick, and the output is high while that count is below a 7-bit duty value. A 2-bit frequency select shortens the period by powers of two: 128, 64, 32 or 16 ticks, giving roughly 250 Hz, 500 Hz, 1 kHz and 2 kHz. Full-scale duty shrinks in step with the period.

Software writes a control byte (run flag and frequency select) and a duty byte. Both take effect on the next clock. A write does not wait for the running period to finish, and no shadow copy is kept. Clearing the run flag forces the output low and returns the counters to zero. Setting it starts a fresh period at tick 0.

In the slowest setting the full-scale count is 128, one more than the duty register can hold. In that setting the output drops low for at least one tick in every period.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset both registers read 0x00 and `pwmOut` is low.
- R2: Address 0 holds the run flag in bit 7 and the frequency select in bits 1:0, with bits 6:2 reading zero. Address 1 holds the 7-bit duty in bits 6:0, with bit 7 reading zero. Other addresses read 0x00, and writes to them change nothing.
- R3: With frequency select m, one period lasts (128 >> m) · TICK_DIV clocks. When the duty d is below 128 >> m, `pwmOut` is high for d · TICK_DIV clocks of each period.
- R4: A duty at or above the full-scale count for selects 1 to 3 (64, 32, 16) gives a constant high output.
- R5: With select 0, the largest duty (0x7F) leaves exactly one tick (TICK_DIV clocks) low per period.
- R6: A duty of 0 gives a constant low output with no pulses.
- R7: While the run flag is clear, `pwmOut` is low. Once the flag is written to 1, `pwmOut` is high from the following clock for d · TICK_DIV clocks, starting at tick 0. The period counter only advances by one or wraps to zero.
- R8: A new duty value applies immediately. If the current tick is already at or past the new duty, `pwmOut` goes low on the second clock after the write, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one clock per write |
| rdData | output | 8 | Read data for `regAddr` (combinational) |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The bench measures high time over whole periods, so a period of the wrong length or an off-by-one compare shows up as a wrong count. The saturation cases each have their own failure mode. Duty 0x7F in the slowest setting must keep one low tick; a design that rounds it to 100% would report full high time. Full-scale duty in the faster settings must stay high; a design that wraps the compare would pulse. Duty 0 must stay low; a greater-or-equal compare would leave a one-tick spike. The bench also checks the first period after enabling, the drop to low after disabling, and a duty cut in mid-period. A design that latched the duty at the period boundary would stay high for dozens more ticks.

// File: rtl/pwm_prescaled_pkg.sv
package pwm_prescaled_pkg;
  localparam int REG_W  = 8;
  localparam int DUTY_W = 7;
  localparam int TICK_W = 8;

  typedef enum logic [1:0] {
    FREQ_X1 = 2'd0,
    FREQ_X2 = 2'd1,
    FREQ_X4 = 2'd2,
    FREQ_X8 = 2'd3
  } freqSel_e;

  // Settings handed from the register block to the datapath
  typedef struct packed {
    logic              runEn;
    freqSel_e          freqSel;
    logic [DUTY_W-1:0] duty;
  } pwmCtl_t;

  // Ticks in one period for a given frequency select
  function automatic logic [TICK_W-1:0] periodTicks(freqSel_e f);
    return TICK_W'(8'h80) >> f;
  endfunction
endpackage

// File: rtl/pwm_prescaled_regs.sv
module pwm_prescaled_regs
  import pwm_prescaled_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              wrEn,
  output logic [REG_W-1:0]  rdData,
  output pwmCtl_t           ctl
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(1);

  logic              runQ;
  freqSel_e          freqQ;
  logic [DUTY_W-1:0] dutyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      freqQ <= FREQ_X1;
      dutyQ <= '0;
    end else if (wrEn) begin
      if (regAddr == ADDR_CTRL) begin
        runQ  <= wrData[REG_W-1];
        freqQ <= freqSel_e'(wrData[1:0]);
      end else if (regAddr == ADDR_DUTY) begin
        dutyQ <= wrData[DUTY_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_CTRL) begin
      rdData[REG_W-1] = runQ;
      rdData[1:0]     = freqQ;
    end else if (regAddr == ADDR_DUTY) begin
      rdData[DUTY_W-1:0] = dutyQ;
    end
  end

  assign ctl = '{runEn: runQ, freqSel: freqQ, duty: dutyQ};
endmodule

// File: rtl/pwm_prescaled_dp.sv
module pwm_prescaled_dp
  import pwm_prescaled_pkg::*;
#(
  parameter int TICK_DIV = 1562
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmCtl_t           ctl,
  output logic [TICK_W-1:0] tickCnt,
  output logic              pwmOut
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic baseTick;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                divCnt <= '0;
        else if (!ctl.runEn)                      divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV - 1))  divCnt <= '0;
        else                                      divCnt <= divCnt + 1'b1;
      end
      assign baseTick = ctl.runEn && (divCnt == DIV_W'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign baseTick = ctl.runEn;
    end
  endgenerate

  logic [TICK_W-1:0] lastTick;
  assign lastTick = periodTicks(ctl.freqSel) - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCnt <= '0;
    else if (!ctl.runEn)        tickCnt <= '0;
    else if (baseTick) begin
      if (tickCnt >= lastTick)  tickCnt <= '0;
      else                      tickCnt <= tickCnt + 1'b1;
    end
  end

  // Registered compare keeps the pin free of decode glitches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmOut <= 1'b0;
    else       pwmOut <= ctl.runEn && ({1'b0, ctl.duty} > tickCnt);
  end
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_prescaled_pkg::*;
#(
  parameter int TICK_DIV = 1562,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  output logic [7:0]        rdData,
  output logic              pwmOut
);
  pwmCtl_t           ctl;
  logic [TICK_W-1:0] tickCnt;

  pwm_prescaled_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData),
    .wrEn(wrEn), .rdData(rdData), .ctl(ctl)
  );

  pwm_prescaled_dp #(.TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tickCnt(tickCnt), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        rdData,
  input logic              pwmOut,
  input logic              runEn,
  input logic [1:0]        freqSel,
  input logic [6:0]        dutyVal,
  input logic [7:0]        tickCnt
);
  logic [7:0] fullCnt;
  assign fullCnt = 8'h80 >> freqSel;

  a_r2_ctrl_mask: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (rdData[6:2] == 5'd0));

  a_r2_duty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(1)) |-> !rdData[7]);

  a_r7_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !pwmOut);

  a_r7_off_clear: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (tickCnt == 8'd0));

  a_r7_step: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $past(runEn)) |->
      ((tickCnt == 8'd0) || (tickCnt == $past(tickCnt)) ||
       (tickCnt == $past(tickCnt) + 8'd1)));

  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    (dutyVal == 7'd0) |=> !pwmOut);

  a_r4_full_high: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && ({1'b0, dutyVal} >= fullCnt) && (tickCnt < fullCnt)) |=> pwmOut);
endmodule

bind pwm_prescaled pwm_prescaled_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdData(rdData),
  .pwmOut(pwmOut), .runEn(ctl.runEn), .freqSel(ctl.freqSel),
  .dutyVal(ctl.duty), .tickCnt(tickCnt)
);

// File: tb/test_pwm_prescaled.sv
module test_pwm_prescaled;
  localparam int DIV    = 4;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0]        wrData = '0;
  logic              wrEn = 1'b0;
  logic [7:0]        rdData;
  logic              pwmOut;

  int nChk = 0;
  int nBad = 0;
  bit summaryDone = 1'b0;

  always #10 clk = ~clk;

  pwm_prescaled #(.TICK_DIV(DIV), .ADDR_W(ADDR_W)) i_pwm_prescaled (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData),
    .wrEn(wrEn), .rdData(rdData), .pwmOut(pwmOut)
  );

  // {freqSel, duty, expected high ticks per period}
  localparam logic [16:0] VEC [10] = '{
    {2'd0, 7'h40, 8'd64},
    {2'd0, 7'h7F, 8'd127},
    {2'd1, 7'h20, 8'd32},
    {2'd1, 7'h40, 8'd64},
    {2'd2, 7'h1F, 8'd31},
    {2'd2, 7'h7F, 8'd32},
    {2'd3, 7'h01, 8'd1},
    {2'd3, 7'h10, 8'd16},
    {2'd3, 7'h0F, 8'd15},
    {2'd1, 7'h00, 8'd0}
  };

  task automatic report();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic countHigh(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int highs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 duty reset", v, 0);
    chk("R1 output reset", pwmOut, 0);

    // R2 readback masks and unmapped address
    wr(2'd0, 8'h7F); rd(2'd0, v); chk("R2 ctrl mask", v, 8'h03);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 duty mask", v, 8'h7F);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 unmapped read", v, 0);
    rd(2'd0, v); chk("R2 unmapped write ctrl", v, 8'h03);
    rd(2'd1, v); chk("R2 unmapped write duty", v, 8'h7F);
    countHigh(300, highs); chk("R7 disabled low", highs, 0);

    // Table walk: R3 R4 R5 R6
    for (int k = 0; k < 10; k++) begin
      logic [1:0] m;
      logic [6:0] d;
      int expHigh;
      string tag;
      m = VEC[k][16:15];
      d = VEC[k][14:8];
      expHigh = int'(VEC[k][7:0]) * DIV;
      if (d == 7'd0)                    tag = "R6 zero duty";
      else if (d >= (7'h40 >> m) && m != 2'd0 && int'(d) >= (128 >> m))
                                        tag = "R4 full scale";
      else if (m == 2'd0 && d == 7'h7F) tag = "R5 slowest max";
      else                              tag = "R3 high time";
      wr(2'd1, {1'b0, d});
      wr(2'd0, {1'b1, 5'd0, m});
      repeat (1100) @(negedge clk);
      countHigh((128 >> m) * DIV, highs);
      chk(tag, highs, expHigh);
    end

    // R7 disable forces low and keeps duty
    wr(2'd1, 8'h7F); wr(2'd0, 8'h81);
    repeat (600) @(negedge clk);
    wr(2'd0, 8'h01);
    @(negedge clk);
    countHigh(300, highs); chk("R7 disable low", highs, 0);
    rd(2'd1, v); chk("R7 duty kept", v, 8'h7F);

    // R7 enable starts at tick 0: one clock of latency, then 5 ticks high
    wr(2'd0, 8'h03); wr(2'd1, 8'h05);
    wr(2'd0, 8'h83);
    chk("R7 low before first edge", pwmOut, 0);
    countHigh(5 * DIV, highs); chk("R7 first pulse", highs, 5 * DIV);
    @(negedge clk); chk("R7 falls after duty", pwmOut, 0);

    // R8 duty cut in mid-period applies at once
    wr(2'd1, 8'd100); wr(2'd0, 8'h80);
    begin
      logic prev;
      int guard;
      prev = pwmOut; guard = 0;
      while (!(pwmOut && !prev) && guard < 2000) begin
        prev = pwmOut;
        @(negedge clk);
        guard++;
      end
    end
    repeat (50 * DIV) @(negedge clk);
    chk("R8 high before cut", pwmOut, 1);
    wr(2'd1, 8'd20);
    @(negedge clk);
    chk("R8 low right after cut", pwmOut, 0);

    report();
    $finish;
  end
endmodule